// File: doc/BRIEF.md
# Dual-Processor Mailbox Channel Controller

This block lets two processors tell each other about messages through a set of channel flags. Each processor owns one flag per channel. It raises its own flag to announce that it has posted a message. The other processor clears that flag to acknowledge that it has consumed the message. Message payloads live elsewhere; this block holds only the flags, the per-side enables and masks, and the interrupt logic.

Each processor has its own single-cycle register port. A write takes effect at the clock edge. A read returns data combinationally in the same cycle it is issued, taken from register state.

Each side has four registers at byte offsets: 0x00 control, 0x04 mask, 0x08 flag set/clear (write-only), and 0x0C status. The field layout is:

- Control: bit 0 is the receive-interrupt enable; bit 1 is the transmit-interrupt enable.
- Mask: bits [5:0] are the occupied masks; bits [21:16] are the free masks.
- Set/clear: bits [21:16] set this side's own flags; bits [5:0] clear the peer's flags.
- Status: bits [5:0] are this side's own flags.

Each side drives two interrupts:

- The receive-occupied interrupt flags a channel the peer has posted.
- The transmit-free interrupt flags a channel whose own flag is clear, so a new message can be posted.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset, on both sides all flags and both enables are 0, and both masks read 0x003F003F. All four interrupts are low.
- R2: A write to set/clear with bit 16+i set raises the writer's own flag for channel i. That side's status reads it at bit i from the next cycle on.
- R3: A write to set/clear with bit i set clears the peer's flag for channel i. Set/clear bits written as 0 leave every flag unchanged.
- R4: If, in one cycle, a side sets its own flag for channel i and the peer clears that same flag, the flag ends up set.
- R5: Both ports may write in the same cycle. Each write has its full effect, and neither disturbs the other.
- R6: A side's receive interrupt is high exactly when its receive enable is 1 and there is a channel whose peer flag is 1 and whose occupied-mask bit is 0.
- R7: A side's transmit interrupt is high exactly when its transmit enable is 1 and there is a channel whose own flag is 0 and whose free-mask bit is 0.
- R8: Control and mask read back what was last written, in the layout given above. Unused bits read 0.
- R9: Reads of set/clear and of any unmapped offset return 0. Writes to status or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_sel | input | 1 | Side 0 access strobe |
| p0_wr | input | 1 | Side 0 write (1) or read (0) |
| p0_addr | input | 5 | Side 0 byte offset |
| p0_wdata | input | 32 | Side 0 write data |
| p0_rdata | output | 32 | Side 0 read data |
| p0_irq_rx | output | 1 | Side 0 receive-occupied interrupt |
| p0_irq_tx | output | 1 | Side 0 transmit-free interrupt |
| p1_sel | input | 1 | Side 1 access strobe |
| p1_wr | input | 1 | Side 1 write (1) or read (0) |
| p1_addr | input | 5 | Side 1 byte offset |
| p1_wdata | input | 32 | Side 1 write data |
| p1_rdata | output | 32 | Side 1 read data |
| p1_irq_rx | output | 1 | Side 1 receive-occupied interrupt |
| p1_irq_tx | output | 1 | Side 1 transmit-free interrupt |

## Verification
Two events can land on the same flag in one cycle: the owner setting it and the peer clearing it. The bench provokes this by writing both ports on one clock edge, aimed at a single channel. A second concurrent write pairs a set on one side with a clear of a different channel on the other. A behavioural model, updated on every edge, applies the peer's clears before the owner's sets. Its interrupt predictions and status values are compared with the design's on every clock and after each read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_MASK   = 'h04;
  localparam int OFF_SETCLR = 'h08;
  localparam int OFF_STATUS = 'h0C;
  localparam int HI_BASE    = 16;
  localparam int MAX_CH     = 16;

  // channels a side may receive from: peer posted and not masked
  function automatic logic [MAX_CH-1:0] pend_rx(logic [MAX_CH-1:0] peer_flags,
                                                logic [MAX_CH-1:0] occ_mask);
    return peer_flags & ~occ_mask;
  endfunction

  // channels a side may post on: own flag free and not masked
  function automatic logic [MAX_CH-1:0] pend_tx(logic [MAX_CH-1:0] own_flags,
                                                logic [MAX_CH-1:0] free_mask);
    return ~own_flags & ~free_mask;
  endfunction

  // next flag value: owner's set beats the peer's clear
  function automatic logic [MAX_CH-1:0] flag_next(logic [MAX_CH-1:0] cur,
                                                  logic [MAX_CH-1:0] set_b,
                                                  logic [MAX_CH-1:0] clr_b);
    return (cur & ~clr_b) | set_b;
  endfunction
endpackage

// File: rtl/mbox_flags.sv
module mbox_flags #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set0,
  input  logic [NCH-1:0] clr0,
  input  logic [NCH-1:0] set1,
  input  logic [NCH-1:0] clr1,
  output logic [NCH-1:0] flag0,
  output logic [NCH-1:0] flag1
);
  localparam int MW = mbox_pkg::MAX_CH;

  logic [NCH-1:0] nxt0, nxt1;
  assign nxt0 = NCH'(mbox_pkg::flag_next(MW'(flag0), MW'(set0), MW'(clr0)));
  assign nxt1 = NCH'(mbox_pkg::flag_next(MW'(flag1), MW'(set1), MW'(clr1)));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag0[i] <= 1'b0;
        flag1[i] <= 1'b0;
      end else begin
        flag0[i] <= nxt0[i];
        flag1[i] <= nxt1[i];
      end
    end
  end

  AST_SET_WINS_0: assert property (@(posedge clk) disable iff (!rst_n)
    (|set0) |=> ((flag0 & $past(set0)) == $past(set0)));  // R4
  AST_SET_WINS_1: assert property (@(posedge clk) disable iff (!rst_n)
    (|set1) |=> ((flag1 & $past(set1)) == $past(set1)));  // R4
  AST_CLR_TAKES_0: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr0 & ~set0)) |=> ((flag0 & $past(clr0 & ~set0)) == '0));  // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set0 == '0 && clr0 == '0 && set1 == '0 && clr1 == '0)
      |=> ($stable(flag0) && $stable(flag1)));  // R3
endmodule

// File: rtl/mbox_side.sv
module mbox_side #(
  parameter int NCH = 6,
  parameter int AW  = 5,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [NCH-1:0] own_flags,
  input  logic [NCH-1:0] peer_flags,
  output logic [NCH-1:0] set_own,
  output logic [NCH-1:0] clr_peer,
  output logic           irq_rx,
  output logic           irq_tx
);
  localparam int HI = mbox_pkg::HI_BASE;
  localparam int MW = mbox_pkg::MAX_CH;
  localparam logic [AW-1:0] A_CTRL = AW'(mbox_pkg::OFF_CTRL);
  localparam logic [AW-1:0] A_MASK = AW'(mbox_pkg::OFF_MASK);
  localparam logic [AW-1:0] A_SC   = AW'(mbox_pkg::OFF_SETCLR);
  localparam logic [AW-1:0] A_STAT = AW'(mbox_pkg::OFF_STATUS);

  logic           rx_en, tx_en;
  logic [NCH-1:0] occ_m, free_m;
  logic [NCH-1:0] rx_pend, tx_pend;
  logic           wr_ctrl, wr_mask, wr_sc, rd_sc;

  assign wr_ctrl = sel && wr && (addr == A_CTRL);
  assign wr_mask = sel && wr && (addr == A_MASK);
  assign wr_sc   = sel && wr && (addr == A_SC);
  assign rd_sc   = sel && !wr && (addr == A_SC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
      occ_m  <= '1;
      free_m <= '1;
    end else begin
      if (wr_ctrl) begin
        rx_en <= wdata[0];
        tx_en <= wdata[1];
      end
      if (wr_mask) begin
        occ_m  <= wdata[NCH-1:0];
        free_m <= wdata[HI +: NCH];
      end
    end
  end

  assign set_own  = wr_sc ? wdata[HI +: NCH] : '0;
  assign clr_peer = wr_sc ? wdata[NCH-1:0]   : '0;

  always_comb begin
    rdata = '0;
    if (sel && !wr) begin
      unique case (addr)
        A_CTRL: rdata[1:0] = {tx_en, rx_en};
        A_MASK: begin
          rdata[NCH-1:0]   = occ_m;
          rdata[HI +: NCH] = free_m;
        end
        A_STAT:  rdata[NCH-1:0] = own_flags;
        default: rdata = '0;
      endcase
    end
  end

  assign rx_pend = NCH'(mbox_pkg::pend_rx(MW'(peer_flags), MW'(occ_m)));
  assign tx_pend = NCH'(mbox_pkg::pend_tx(MW'(own_flags), MW'(free_m)));
  assign irq_rx  = rx_en && (|rx_pend);
  assign irq_tx  = tx_en && (|tx_pend);

  logic unused_ok;
  assign unused_ok = ^wdata;

  AST_RX_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> ((peer_flags & ~occ_m) != '0));  // R6
  AST_TX_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> ((~own_flags & ~free_m) != '0));  // R7
  AST_SC_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sc |-> (rdata == '0));  // R9
  AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (rx_en == $past(wdata[0]) && tx_en == $past(wdata[1])));  // R8
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl #(
  parameter int NCH = 6,
  parameter int AW  = 5,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p0_sel,
  input  logic          p0_wr,
  input  logic [AW-1:0] p0_addr,
  input  logic [DW-1:0] p0_wdata,
  output logic [DW-1:0] p0_rdata,
  output logic          p0_irq_rx,
  output logic          p0_irq_tx,
  input  logic          p1_sel,
  input  logic          p1_wr,
  input  logic [AW-1:0] p1_addr,
  input  logic [DW-1:0] p1_wdata,
  output logic [DW-1:0] p1_rdata,
  output logic          p1_irq_rx,
  output logic          p1_irq_tx
);
  logic [NCH-1:0] flag0, flag1;
  logic [NCH-1:0] set0, set1, clr_of0, clr_of1;

  mbox_side #(.NCH(NCH), .AW(AW), .DW(DW)) u_side0 (
    .clk(clk), .rst_n(rst_n), .sel(p0_sel), .wr(p0_wr), .addr(p0_addr),
    .wdata(p0_wdata), .rdata(p0_rdata), .own_flags(flag0), .peer_flags(flag1),
    .set_own(set0), .clr_peer(clr_of1), .irq_rx(p0_irq_rx), .irq_tx(p0_irq_tx));

  mbox_side #(.NCH(NCH), .AW(AW), .DW(DW)) u_side1 (
    .clk(clk), .rst_n(rst_n), .sel(p1_sel), .wr(p1_wr), .addr(p1_addr),
    .wdata(p1_wdata), .rdata(p1_rdata), .own_flags(flag1), .peer_flags(flag0),
    .set_own(set1), .clr_peer(clr_of0), .irq_rx(p1_irq_rx), .irq_tx(p1_irq_tx));

  mbox_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n), .set0(set0), .clr0(clr_of0),
    .set1(set1), .clr1(clr_of1), .flag0(flag0), .flag1(flag1));

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!p0_irq_rx && !p0_irq_tx && !p1_irq_rx && !p1_irq_tx));  // R1
endmodule

// File: tb/mbox_ctrl_tb_top.sv
module mbox_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        sel [2];
  logic        wr  [2];
  logic [4:0]  adr [2];
  logic [31:0] wd  [2];
  logic [31:0] rd  [2];
  logic        irx [2];
  logic        itx [2];

  mbox_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .p0_sel(sel[0]), .p0_wr(wr[0]), .p0_addr(adr[0]), .p0_wdata(wd[0]),
    .p0_rdata(rd[0]), .p0_irq_rx(irx[0]), .p0_irq_tx(itx[0]),
    .p1_sel(sel[1]), .p1_wr(wr[1]), .p1_addr(adr[1]), .p1_wdata(wd[1]),
    .p1_rdata(rd[1]), .p1_irq_rx(irx[1]), .p1_irq_tx(itx[1]));

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model
  bit [5:0] m_flag [2];
  bit [5:0] m_occ  [2];
  bit [5:0] m_free [2];
  bit       m_rxen [2];
  bit       m_txen [2];

  always @(posedge clk) begin
    bit [5:0] s_b [2];
    bit [5:0] c_b [2];
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        m_flag[s] = 0; m_occ[s] = 6'h3F; m_free[s] = 6'h3F;
        m_rxen[s] = 0; m_txen[s] = 0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        s_b[s] = 0; c_b[s] = 0;
        if (sel[s] && wr[s]) begin
          if (adr[s] == 5'h00) begin m_rxen[s] = wd[s][0]; m_txen[s] = wd[s][1]; end
          if (adr[s] == 5'h04) begin m_occ[s] = wd[s][5:0]; m_free[s] = wd[s][21:16]; end
          if (adr[s] == 5'h08) begin s_b[s] = wd[s][21:16]; c_b[s] = wd[s][5:0]; end
        end
      end
      for (int s = 0; s < 2; s++) begin
        for (int ch = 0; ch < 6; ch++) begin
          if (c_b[1-s][ch]) m_flag[s][ch] = 0;
          if (s_b[s][ch]) m_flag[s][ch] = 1;
        end
      end
    end
  end

  function automatic bit exp_rx(int s);
    bit any = 0;
    for (int ch = 0; ch < 6; ch++)
      if (m_flag[1-s][ch] && !m_occ[s][ch]) any = 1;
    return m_rxen[s] && any;
  endfunction

  function automatic bit exp_tx(int s);
    bit any = 0;
    for (int ch = 0; ch < 6; ch++)
      if (!m_flag[s][ch] && !m_free[s][ch]) any = 1;
    return m_txen[s] && any;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // interrupt lines compared with the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int s = 0; s < 2; s++) begin
        check("R6 irq_rx", 32'(irx[s]), 32'(exp_rx(s)));
        check("R7 irq_tx", 32'(itx[s]), 32'(exp_tx(s)));
      end
    end
  end

  task automatic wr_one(int s, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    sel[s] = 1; wr[s] = 1; adr[s] = a; wd[s] = d;
    @(posedge clk); #1;
    sel[s] = 0; wr[s] = 0; wd[s] = 0;
  endtask

  task automatic wr_both(logic [4:0] a0, logic [31:0] d0, logic [4:0] a1, logic [31:0] d1);
    @(negedge clk);
    sel[0] = 1; wr[0] = 1; adr[0] = a0; wd[0] = d0;
    sel[1] = 1; wr[1] = 1; adr[1] = a1; wd[1] = d1;
    @(posedge clk); #1;
    for (int s = 0; s < 2; s++) begin sel[s] = 0; wr[s] = 0; wd[s] = 0; end
  endtask

  task automatic rd_chk(string req, int s, logic [4:0] a, logic [31:0] exp);
    @(negedge clk);
    sel[s] = 1; wr[s] = 0; adr[s] = a;
    #1;
    check(req, rd[s], exp);
    sel[s] = 0;
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin sel[s] = 0; wr[s] = 0; adr[s] = 0; wd[s] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int s = 0; s < 2; s++) begin
      rd_chk("R1 status", s, 5'h0C, 32'h0);
      rd_chk("R1 ctrl", s, 5'h00, 32'h0);
      rd_chk("R1 mask", s, 5'h04, 32'h003F003F);
      check("R1 irqs", {irx[s], itx[s]}, 32'h0);
    end
    // R8 readback
    wr_one(0, 5'h00, 32'hFFFF_FFFF);
    rd_chk("R8 ctrl", 0, 5'h00, 32'h3);
    wr_one(0, 5'h04, 32'hFFC0_FFC0);
    rd_chk("R8 mask", 0, 5'h04, 32'h0);
    wr_one(1, 5'h00, 32'h3);
    wr_one(1, 5'h04, 32'h0);
    rd_chk("R7 tx free", 0, 5'h0C, 32'h0);
    // R2 set own flag
    wr_one(0, 5'h08, 32'h0004_0000);
    rd_chk("R2 status", 0, 5'h0C, 32'h4);
    rd_chk("R2 peer untouched", 1, 5'h0C, 32'h0);
    // R3 zero bits no effect, then clear
    wr_one(1, 5'h08, 32'h0);
    rd_chk("R3 zero write", 0, 5'h0C, 32'h4);
    wr_one(1, 5'h08, 32'h0000_0004);
    rd_chk("R3 clear", 0, 5'h0C, 32'h0);
    // R9 writes to status / unmapped ignored, reads of set/clear and unmapped are 0
    wr_one(0, 5'h0C, 32'h3F);
    wr_one(0, 5'h10, 32'hFFFF_FFFF);
    rd_chk("R9 status write", 0, 5'h0C, 32'h0);
    rd_chk("R9 ctrl after unmapped", 0, 5'h00, 32'h3);
    rd_chk("R9 setclr read", 0, 5'h08, 32'h0);
    rd_chk("R9 unmapped read", 1, 5'h14, 32'h0);
    // R4 set and peer clear of same flag in one cycle
    wr_one(0, 5'h08, 32'h0001_0000);
    wr_both(5'h08, 32'h0002_0000, 5'h08, 32'h0000_0003);
    rd_chk("R4 set wins", 0, 5'h0C, 32'h2);
    // R5 independent concurrent writes
    wr_one(1, 5'h08, 32'h0001_0000);
    wr_both(5'h08, 32'h0020_0001, 5'h08, 32'h0008_0000);
    rd_chk("R5 side0", 0, 5'h0C, 32'h22);
    rd_chk("R5 side1", 1, 5'h0C, 32'h08);
    wr_both(5'h04, 32'h0000_003F, 5'h00, 32'h2);
    rd_chk("R5 mask0", 0, 5'h04, 32'h3F);
    rd_chk("R5 ctrl1", 1, 5'h00, 32'h2);
    // R6 masking of receive interrupt
    wr_one(1, 5'h00, 32'h3);
    wr_one(1, 5'h04, 32'h0000_0022);
    wr_one(1, 5'h04, 32'h0000_0002);
    // R7 all own flags set removes transmit source
    wr_one(0, 5'h04, 32'h0);
    wr_one(0, 5'h08, 32'h003F_0000);
    rd_chk("R7 all set", 0, 5'h0C, 32'h3F);
    wr_one(1, 5'h08, 32'h0000_0010);
    wr_one(0, 5'h04, 32'h0010_0000);
    wr_one(0, 5'h00, 32'h1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule